// File: doc/BRIEF.md
# I/O Port Permission Checker

This block sits between the processor's port-access path and the I/O bus. Each request carries a 16-bit port number, an access width, the current privilege level and the 2-bit I/O privilege level from the flags register. The block grants the access and forwards it to the I/O bus strobe, or it denies the access and raises a one-cycle fault pulse in place of the bus cycle. The I/O space is untranslated, so the port number reaches the bus unchanged.

Two checks run in order. The first is a privilege comparison. A caller whose current privilege is numerically no greater than the I/O privilege level passes without further tests. Any other caller is checked against a permission bitmap that holds one bit for each port byte across the whole 64 KB port space. That check covers every byte touched by a 16-bit or 32-bit access. Software fills the bitmap one 32-bit word at a time through a write port. Accesses that run past the top of the port space, and accesses with the reserved width code, are always denied.

Top module: `iopPermChk`

## Requirements
- R1: After reset, busStrobe and permFault are low and every bitmap bit is 1, so every access from a caller with curPriv greater than ioPriv is denied.
- R2: A request sampled at a rising edge with reqValid high produces its outcome on the next cycle. Exactly one of busStrobe and permFault is high for that one cycle, and busPort and busSize show the request's port and width code.
- R3: When curPriv is numerically at most ioPriv, a request with a legal width that does not wrap is granted, whatever the bitmap holds.
- R4: Port p is governed by bit p[4:0] of bitmap word p[15:5]. A bit value of 1 denies the port and 0 permits it. Pulsing mapWrEn writes mapWrData into word mapWrIdx.
- R5: Width codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A low-privilege access covers ports p to p+n-1 and is granted only if all of those bits are 0.
- R6: A multi-byte access that straddles two bitmap words is checked against the bits in both words.
- R7: An access whose last byte lies beyond port 0xFFFF is denied at every privilege level.
- R8: Width code 3 is reserved and is denied at every privilege level.
- R9: busStrobe and permFault are never high together, and neither is high in a cycle that does not follow a request.
- R10: A bitmap write and a request in the same cycle: the request is judged on the old bitmap contents, and the new word governs requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqPort | input | 16 | First port byte of the access |
| reqSize | input | 2 | Width code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| curPriv | input | 2 | Current privilege level of the requester |
| ioPriv | input | 2 | I/O privilege level field of the flags register |
| mapWrEn | input | 1 | Bitmap word write enable |
| mapWrIdx | input | 11 | Bitmap word index |
| mapWrData | input | 32 | Bitmap word value, bit k governs port 32*index+k |
| busStrobe | output | 1 | One-cycle grant strobe towards the I/O bus |
| busPort | output | 16 | Port of the last request |
| busSize | output | 2 | Width code of the last request |
| permFault | output | 1 | One-cycle exception pulse for a denied access |

## Verification
Every outcome and its forwarded port and width are due in the cycle after the edge that samples the request. A bitmap write is due to affect requests sampled at later edges only. The driver applies stimulus on the falling edge and queues the expected outcome. The monitor wakes two time units after each rising edge and pops one item for every request that edge sampled. When the queue is empty it requires both outcome pulses to be low. This holds each result to its exact cycle, and it catches a stray pulse in a cycle after a write alone.

// File: rtl/iopChkPkg.sv
package iopChkPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_GRANT = 2'd1,
    OUT_FAULT = 2'd2
  } outcome_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mapWrite;
    logic capture;
  } dpStrobe_t;

  localparam int MAX_ACC_BYTES = 4;

endpackage

// File: rtl/iopChkDatapath.sv
module iopChkDatapath
  import iopChkPkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int MAP_WORD_W = 32,
  localparam int OFF_W     = $clog2(MAP_WORD_W),
  localparam int IDX_W     = PORT_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [1:0]        reqSize,
  input  logic [IDX_W-1:0]  mapWrIdx,
  input  logic [MAP_WORD_W-1:0] mapWrData,
  output logic              mapDeny,
  output logic              portWrap,
  output logic [PORT_W-1:0] busPort,
  output logic [1:0]        busSize
);

  localparam int WORDS      = 2 ** IDX_W;
  localparam int PAIR_W     = 2 * MAP_WORD_W;
  localparam int PAIR_IDX_W = OFF_W + 1;

  logic [MAP_WORD_W-1:0] mapMem [WORDS];

  logic [IDX_W-1:0]         lineIdx;
  logic [IDX_W-1:0]         nextIdx;
  logic [OFF_W-1:0]         bitOff;
  logic [PAIR_W-1:0]        pairWord;
  logic [MAX_ACC_BYTES-1:0] byteMask;
  logic [MAX_ACC_BYTES-1:0] byteHit;
  logic [1:0]               lastOff;
  logic [PORT_W:0]          endPort;

  // bitmap storage, all ports denied out of reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mapMem[i] <= '1;
    end else if (strobes.mapWrite) begin
      mapMem[mapWrIdx] <= mapWrData;
    end
  end

  assign lineIdx  = reqPort[PORT_W-1:OFF_W];
  assign bitOff   = reqPort[OFF_W-1:0];
  assign nextIdx  = lineIdx + IDX_W'(1);
  assign pairWord = {mapMem[nextIdx], mapMem[lineIdx]};

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: begin byteMask = 4'b0001; lastOff = 2'd0; end
      SZ_HALF: begin byteMask = 4'b0011; lastOff = 2'd1; end
      default: begin byteMask = 4'b1111; lastOff = 2'd3; end
    endcase
  end

  // one permission bit per byte the access touches
  for (genvar b = 0; b < MAX_ACC_BYTES; b++) begin : g_byte
    assign byteHit[b] = byteMask[b] &
                        pairWord[PAIR_IDX_W'(bitOff) + PAIR_IDX_W'(b)];
  end

  assign mapDeny  = |byteHit;
  assign endPort  = {1'b0, reqPort} + (PORT_W+1)'(lastOff);
  assign portWrap = endPort[PORT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busPort <= '0;
      busSize <= '0;
    end else if (strobes.capture) begin
      busPort <= reqPort;
      busSize <= reqSize;
    end
  end

  AST_FWD_PORT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (busPort == $past(reqPort)) && (busSize == $past(reqSize))); // R2

  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mapWrite |=> mapMem[$past(mapWrIdx)] == $past(mapWrData)); // R4

endmodule

// File: rtl/iopChkCtrl.sv
module iopChkCtrl
  import iopChkPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] reqSize,
  input  logic [1:0] curPriv,
  input  logic [1:0] ioPriv,
  input  logic      mapWrEn,
  input  logic      mapDeny,
  input  logic      portWrap,
  output dpStrobe_t strobes,
  output logic      busStrobe,
  output logic      permFault
);

  logic     sizeOk;
  logic     privOk;
  logic     grantNow;
  outcome_e outcomeQ;
  outcome_e outcomeD;

  assign sizeOk   = accSize_e'(reqSize) != SZ_RSVD;
  assign privOk   = curPriv <= ioPriv;
  assign grantNow = sizeOk && !portWrap && (privOk || !mapDeny);

  assign strobes.mapWrite = mapWrEn;
  assign strobes.capture  = reqValid;

  always_comb begin
    if (!reqValid)     outcomeD = OUT_IDLE;
    else if (grantNow) outcomeD = OUT_GRANT;
    else               outcomeD = OUT_FAULT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outcomeQ <= OUT_IDLE;
    else       outcomeQ <= outcomeD;
  end

  assign busStrobe = outcomeQ == OUT_GRANT;
  assign permFault = outcomeQ == OUT_FAULT;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(busStrobe && permFault)); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !busStrobe && !permFault); // R9

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> busStrobe || permFault); // R2

  AST_PRIV_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize != 2'd3 && !portWrap && curPriv <= ioPriv |=> busStrobe); // R3

  AST_WRAP_DENY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && portWrap |=> permFault); // R7

  AST_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'd3 |=> permFault); // R8

endmodule

// File: rtl/iopPermChk.sv
module iopPermChk
  import iopChkPkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int MAP_WORD_W = 32,
  localparam int IDX_W     = PORT_W - $clog2(MAP_WORD_W)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [PORT_W-1:0]     reqPort,
  input  logic [1:0]            reqSize,
  input  logic [1:0]            curPriv,
  input  logic [1:0]            ioPriv,
  input  logic                  mapWrEn,
  input  logic [IDX_W-1:0]      mapWrIdx,
  input  logic [MAP_WORD_W-1:0] mapWrData,
  output logic                  busStrobe,
  output logic [PORT_W-1:0]     busPort,
  output logic [1:0]            busSize,
  output logic                  permFault
);

  dpStrobe_t strobes;
  logic      mapDeny;
  logic      portWrap;

  iopChkCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSize  (reqSize),
    .curPriv  (curPriv),
    .ioPriv   (ioPriv),
    .mapWrEn  (mapWrEn),
    .mapDeny  (mapDeny),
    .portWrap (portWrap),
    .strobes  (strobes),
    .busStrobe(busStrobe),
    .permFault(permFault)
  );

  iopChkDatapath #(
    .PORT_W    (PORT_W),
    .MAP_WORD_W(MAP_WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqPort  (reqPort),
    .reqSize  (reqSize),
    .mapWrIdx (mapWrIdx),
    .mapWrData(mapWrData),
    .mapDeny  (mapDeny),
    .portWrap (portWrap),
    .busPort  (busPort),
    .busSize  (busSize)
  );

endmodule

// File: tb/iopPermChk_tb.sv
module iopPermChk_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        grant;
    logic [15:0] port;
    logic [1:0]  size;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [15:0] reqPort;
  logic [1:0]  reqSize;
  logic [1:0]  curPriv;
  logic [1:0]  ioPriv;
  logic        mapWrEn;
  logic [10:0] mapWrIdx;
  logic [31:0] mapWrData;
  logic        busStrobe;
  logic [15:0] busPort;
  logic [1:0]  busSize;
  logic        permFault;

  int total = 0;
  int bad   = 0;
  expItem_t expQ [$];
  logic [31:0] mdl [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  iopPermChk u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqSize(reqSize), .curPriv(curPriv), .ioPriv(ioPriv),
    .mapWrEn(mapWrEn), .mapWrIdx(mapWrIdx), .mapWrData(mapWrData),
    .busStrobe(busStrobe), .busPort(busPort), .busSize(busSize),
    .permFault(permFault)
  );

  // expected decision from the requirements
  function automatic logic predict(input logic [15:0] p, input logic [1:0] sz,
                                   input logic [1:0] cpl, input logic [1:0] iopl);
    int n;
    if (sz == 2'd3) return 1'b0;                 // R8
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (int'(p) + n > 65536) return 1'b0;         // R7
    if (cpl <= iopl) return 1'b1;                 // R3
    for (int b = 0; b < n; b++) begin             // R4 R5 R6
      int q;
      q = int'(p) + b;
      if (mdl[q / 32][q % 32]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic setReq(input logic [15:0] p, input logic [1:0] sz,
                        input logic [1:0] cpl, input logic [1:0] iopl, input string tag);
    expItem_t it;
    reqValid = 1'b1; reqPort = p; reqSize = sz; curPriv = cpl; ioPriv = iopl;
    it.grant = predict(p, sz, cpl, iopl);
    it.port = p; it.size = sz; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic access(input logic [15:0] p, input logic [1:0] sz,
                        input logic [1:0] cpl, input logic [1:0] iopl, input string tag);
    setReq(p, sz, cpl, iopl, tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic loadWord(input logic [10:0] idx, input logic [31:0] val);
    mapWrEn = 1'b1; mapWrIdx = idx; mapWrData = val;
    @(negedge clk);
    mapWrEn = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic loadAndAccess(input logic [10:0] idx, input logic [31:0] val,
                               input logic [15:0] p, input logic [1:0] sz,
                               input logic [1:0] cpl, input logic [1:0] iopl, input string tag);
    setReq(p, sz, cpl, iopl, tag);     // judged on old contents (R10)
    mapWrEn = 1'b1; mapWrIdx = idx; mapWrData = val;
    @(negedge clk);
    mapWrEn = 1'b0; reqValid = 1'b0;
    mdl[idx] = val;
  endtask

  // monitor: outcome due two time units after the sampling edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (busStrobe !== it.grant || permFault !== !it.grant ||
            busPort !== it.port || busSize !== it.size) begin
          bad++;
          $display("FAIL %s R2: strobe=%b fault=%b port=%h size=%0d expected strobe=%b fault=%b port=%h size=%0d",
                   it.tag, busStrobe, permFault, busPort, busSize,
                   it.grant, !it.grant, it.port, it.size);
        end
      end else begin
        total++;
        if (busStrobe !== 1'b0 || permFault !== 1'b0) begin
          bad++;
          $display("FAIL R9 idle: strobe=%b fault=%b expected strobe=0 fault=0",
                   busStrobe, permFault);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mdl[i] = '1;   // R1 reset contents
    rstN = 1'b0; reqValid = 1'b0; reqPort = '0; reqSize = '0;
    curPriv = '0; ioPriv = '0; mapWrEn = 1'b0; mapWrIdx = '0; mapWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);                               // idle check after reset, R1

    access(16'h0010, 2'd0, 2'd3, 2'd0, "R1 deny after reset");
    access(16'hFFF0, 2'd2, 2'd1, 2'd0, "R1 deny after reset wide");
    access(16'h0010, 2'd0, 2'd0, 2'd0, "R3 equal privilege");
    access(16'h0010, 2'd2, 2'd2, 2'd3, "R3 below iopl");

    loadWord(11'd0, 32'h0000_0008);               // only port 3 denied in word 0
    access(16'h0002, 2'd0, 2'd3, 2'd0, "R4 permitted byte");
    access(16'h0003, 2'd0, 2'd3, 2'd0, "R4 denied byte");
    access(16'h0002, 2'd1, 2'd3, 2'd0, "R5 half touches denied");
    access(16'h0000, 2'd2, 2'd3, 2'd0, "R5 word touches denied");
    access(16'h0004, 2'd2, 2'd3, 2'd0, "R5 word clear");
    setReq(16'h0003, 2'd0, 2'd3, 2'd3, "R3 bypass denied bit");   // back to back
    @(negedge clk);
    access(16'h0001, 2'd1, 2'd3, 2'd1, "R5 half clear");

    loadWord(11'd1, 32'hFFFF_FFFE);               // only port 32 permitted in word 1
    access(16'h001E, 2'd1, 2'd3, 2'd0, "R6 half end of word");
    access(16'h001F, 2'd1, 2'd3, 2'd0, "R6 half straddle ok");
    access(16'h001F, 2'd2, 2'd3, 2'd0, "R6 word straddle denied");
    access(16'h0021, 2'd0, 2'd3, 2'd0, "R4 denied in word 1");

    loadWord(11'd2047, 32'h0000_0000);
    access(16'hFFFF, 2'd0, 2'd3, 2'd0, "R7 last byte ok");
    access(16'hFFFE, 2'd1, 2'd3, 2'd0, "R7 last half ok");
    access(16'hFFFF, 2'd1, 2'd0, 2'd3, "R7 half wraps high priv");
    access(16'hFFFD, 2'd2, 2'd3, 2'd0, "R7 word wraps");
    access(16'hFFFC, 2'd2, 2'd0, 2'd0, "R7 word fits");

    access(16'h0004, 2'd3, 2'd0, 2'd3, "R8 reserved width high priv");
    access(16'h0004, 2'd3, 2'd3, 2'd0, "R8 reserved width");

    loadAndAccess(11'd0, 32'h0000_0000, 16'h0003, 2'd0, 2'd3, 2'd0, "R10 old contents");
    access(16'h0003, 2'd0, 2'd3, 2'd0, "R10 new contents");

    loadWord(11'd5, 32'hA5A5_0F3C);
    for (int p = 16'h00A0; p < 16'h00C2; p++) begin
      for (int s = 0; s < 3; s++) begin
        access(16'(p), 2'(s), 2'd2, 2'd1, "R5 sweep");
      end
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule